// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus that stores six 8-bit configuration bytes for a clock generator. The six bytes leave the block in parallel and feed the output-enable and frequency-select logic next to it. Both bus lines are oversampled by a fast system clock. The slave pulls the data line low through an open-drain enable and never drives it high.

The slave answers a single fixed 7-bit address. A write always carries a command byte and a count byte first. The slave acknowledges both and then discards their values. The data bytes that follow fill the registers from register 0 upward, with no register addressing. A read returns a byte count first and then the registers in ascending order.

A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Both bus inputs pass through a two-stage synchroniser before edge detection. The design assumes a bit rate of 100 kbit/s or below, so each SCL phase spans many system clocks. The configuration bytes form a plain parallel vector and carry no valid/ready handshake: consumers may sample them at any time. A byte changes only when a write to it is acknowledged.

Top module: `cfg_serial_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read), which is device address 0x69 with the read/write flag in bit 0. For any other address it stays silent for the rest of the transfer and changes no register.
- R2: On a write, the two bytes after the address are acknowledged and their values are discarded.
- R3: The write bytes after those two are stored into register 0, 1, 2 and so on in ascending order. Each byte is acknowledged.
- R4: A stop after any complete byte keeps the registers already written and leaves every other register at its old value.
- R5: On a write, bytes beyond the sixth data byte are acknowledged and change no register.
- R6: After reset the registers read 0x0F, 0xFF, 0xFF, 0x00, 0x00 and 0x06 for register 0 through 5. Register k appears on cfg_o[8k+7:8k].
- R7: A read returns the value 6 first and then registers 0 to 5. Each byte is sent most significant bit first, and the next byte follows only after a host acknowledge.
- R8: Read bytes requested past register 5 return 0xFF. A host not-acknowledge ends the read with SDA released.
- R9: A start or a stop at any point aborts the transfer and releases SDA. After a repeated start, a write again begins with register 0.
- R10: sda_oe_o = 1 means SDA is pulled low. It changes only while SCL is low and is 0 whenever the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| cfg_o | output | 48 | Six configuration bytes, register k in bits 8k+7:8k |

## Verification
The SCL and SDA pins pass through two synchroniser flops and one edge register. The data-line enable therefore moves three system clocks after SCL falls at the pin. A stored byte appears on cfg_o four clocks after the falling edge that closes its eighth bit. The bench holds each SCL quarter period for ten clocks. It samples SDA in the middle of the high phase and reads cfg_o twenty clocks after a stop, which is well past every one of these latencies. A port monitor checks on every negative clock edge that the enable never moves while SCL has been high for two samples.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
  localparam int               CFG_NREGS    = 6;
  localparam logic [6:0]       CFG_DEV_ADDR = 7'h69;
  // register 5 .. register 0
  localparam logic [8*CFG_NREGS-1:0] CFG_RESET = 48'h06_00_00_FF_FF_0F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_RD_LOAD
  } slv_state_e;
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] scl_sh;
  logic [LAST:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sh[LAST-1];
  assign scl_old = scl_sh[LAST];
  assign sda_now = sda_sh[LAST-1];
  assign sda_old = sda_sh[LAST];

  assign scl_hi    = scl_now;
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/cfg_proto_fsm.sv
module cfg_proto_fsm
  import cfg_slave_pkg::*;
#(
  parameter int         NREGS    = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] pos
);
  slv_state_e state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       rw;
  logic [IDX_W-1:0] data_idx;
  logic [IDX_W-1:0] pos_inc;

  assign data_idx = pos - IDX_W'(2);
  assign pos_inc  = (pos == '1) ? pos : pos + IDX_W'(1);
  assign wr_idx   = data_idx;
  assign wr_data  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      pos     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        pos     <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_WR_ACK;
                if (pos >= IDX_W'(2) && data_idx < IDX_W'(NREGS))
                  wr_en <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              state  <= ST_RD_BYTE;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR_BYTE;
            end
          end
          ST_WR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            pos    <= pos_inc;
            state  <= ST_WR_BYTE;
          end
          ST_RD_BYTE: if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              bit_cnt <= bit_cnt + 4'd1;
              shreg   <= {shreg[6:0], 1'b0};
              sda_oe  <= ~shreg[6];
            end
          end
          ST_RD_ACK: if (scl_rise) begin
            if (sda_lvl) begin
              state <= ST_IDLE;
            end else begin
              pos   <= pos_inc;
              state <= ST_RD_LOAD;
            end
          end
          ST_RD_LOAD: if (scl_fall) begin
            shreg   <= rd_byte;
            sda_oe  <= ~rd_byte[7];
            bit_cnt <= '0;
            state   <= ST_RD_BYTE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int                 NREGS     = 6,
  parameter logic [8*NREGS-1:0] RESET_VAL = '0,
  parameter int                 IDX_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IDX_W-1:0]   rd_pos,
  output logic [7:0]         rd_byte,
  output logic [8*NREGS-1:0] cfg_o
);
  logic [7:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= RESET_VAL[8*g +: 8];
      else if (wr_en && wr_idx == IDX_W'(g))
        regs[g] <= wr_data;
    end
    assign cfg_o[8*g +: 8] = regs[g];
  end

  always_comb begin
    rd_byte = 8'hFF;
    if (rd_pos == '0) rd_byte = 8'(NREGS);
    for (int k = 0; k < NREGS; k++)
      if (rd_pos == IDX_W'(k + 1)) rd_byte = regs[k];
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_slave_pkg::*;
#(
  parameter int                     NUM_REGS    = CFG_NREGS,
  parameter logic [6:0]             DEV_ADDR    = CFG_DEV_ADDR,
  parameter logic [8*NUM_REGS-1:0]  RESET_VAL   = CFG_RESET,
  parameter int                     SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS + 3) + 1;

  logic scl_hi, scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx, pos;
  logic [7:0] wr_data, rd_byte;

  cfg_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det)
  );

  cfg_proto_fsm #(.NREGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .pos(pos)
  );

  cfg_reg_bank #(.NREGS(NUM_REGS), .RESET_VAL(RESET_VAL), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_pos(pos), .rd_byte(rd_byte), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int                     NUM_REGS  = 6,
  parameter logic [8*NUM_REGS-1:0]  RESET_VAL = '0,
  parameter int                     IDX_W     = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_hi,
  input logic                  stop_det,
  input logic                  sda_oe_o,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [8*NUM_REGS-1:0] cfg_o
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_o == RESET_VAL); // R6

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi)) |-> $stable(sda_oe_o)); // R10

  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cfg_o)); // R4

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx < IDX_W'(NUM_REGS)); // R5

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o); // R9
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(
  .NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .stop_det(stop_det),
  .sda_oe_o(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .cfg_o(cfg_o)
);

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic [47:0] cfg;
  wire  sda_line = host_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic scl_q = 1'b1, oe_q = 1'b0, oe_bad = 1'b0;

  always #4 clk = ~clk;

  cfg_serial_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  // R10 monitor: enable must not move while SCL stays high
  always @(negedge clk) begin
    if (rst_n && scl && scl_q && sda_oe != oe_q) oe_bad <= 1'b1;
    scl_q <= scl;
    oe_q  <= sda_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q_wait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    host_sda = 1'b1; q_wait(); scl = 1'b1; q_wait();
    host_sda = 1'b0; q_wait(); scl = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; q_wait(); scl = 1'b1; q_wait();
    host_sda = 1'b1; q_wait();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    host_sda = b; q_wait(); scl = 1'b1; q_wait();
    seen = sda_line; q_wait(); scl = 1'b0; q_wait();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack);
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~host_ack, s);
    host_sda = 1'b1;
  endtask

  task automatic write_txn(input int n, input logic [63:0] data);
    logic a;
    bus_start();
    put_byte(8'hD2, a); chk("R1 write address ack", 64'(a), 64'd0);
    put_byte(8'hAA, a); chk("R2 command ack", 64'(a), 64'd0);
    put_byte(8'h55, a); chk("R2 count ack", 64'(a), 64'd0);
    for (int k = 0; k < n; k++) begin
      put_byte(data[8*k +: 8], a);
      chk(k < 6 ? "R3 data ack" : "R5 excess ack", 64'(a), 64'd0);
    end
    bus_stop();
    repeat (20) @(negedge clk);
  endtask

  // {data byte count, data (byte k at 8k), expected cfg (reg k at 8k)}
  localparam logic [115:0] VEC [5] = '{
    {4'd6, 64'h0000_6655_4433_2211, 48'h6655_4433_2211},
    {4'd2, 64'h0000_0000_0000_A1A0, 48'h6655_4433_A1A0},
    {4'd0, 64'h0000_0000_0000_0000, 48'h6655_4433_A1A0},
    {4'd8, 64'hC7C6_C5C4_C3C2_C1C0, 48'hC5C4_C3C2_C1C0},
    {4'd3, 64'h0000_0000_0003_0201, 48'hC5C4_C303_0201}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    logic [47:0] exp_rd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 reset values", 64'(cfg), 64'h0006_00_00_FF_FF_0F);
    chk("R10 idle release", 64'(sda_oe), 64'd0);

    for (int v = 0; v < 5; v++) begin
      write_txn(int'(VEC[v][115:112]), VEC[v][111:48]);
      chk("R3 R4 R5 table result", 64'(cfg), 64'(VEC[v][47:0]));
    end

    // R1: foreign address is not acknowledged, nothing changes
    bus_start();
    put_byte(8'hA0, a); chk("R1 foreign address nack", 64'(a), 64'd1);
    put_byte(8'h00, a); put_byte(8'h11, a); put_byte(8'h22, a);
    chk("R1 silent after foreign", 64'(a), 64'd1);
    bus_stop(); repeat (20) @(negedge clk);
    chk("R1 regs untouched", 64'(cfg), 64'h0000_C5C4_C303_0201);

    // R9: repeated start restarts write at register 0
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h01, a); put_byte(8'h02, a);
    put_byte(8'h5A, a); put_byte(8'h5B, a);
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h01, a); put_byte(8'h02, a);
    put_byte(8'h77, a);
    bus_stop(); repeat (20) @(negedge clk);
    chk("R9 restart rewrites reg0", 64'(cfg), 64'h0000_C5C4_C303_5B77);

    // R7, R8: full read back with one byte past the end
    exp_rd = 48'hC5C4_C303_5B77;
    bus_start();
    put_byte(8'hD3, a); chk("R1 read address ack", 64'(a), 64'd0);
    get_byte(1'b1, b); chk("R7 byte count", 64'(b), 64'd6);
    for (int k = 0; k < 6; k++) begin
      get_byte(1'b1, b); chk("R7 register read", 64'(b), 64'(exp_rd[8*k +: 8]));
    end
    get_byte(1'b0, b); chk("R8 past end", 64'(b), 64'hFF);
    repeat (5) @(negedge clk);
    chk("R8 released after nack", 64'(sda_oe), 64'd0);
    bus_stop(); repeat (20) @(negedge clk);

    // R8: nack right after the count ends the read
    bus_start();
    put_byte(8'hD3, a);
    get_byte(1'b0, b); chk("R7 count again", 64'(b), 64'd6);
    repeat (5) @(negedge clk);
    chk("R8 nack after count", 64'(sda_oe), 64'd0);
    bus_stop(); repeat (20) @(negedge clk);

    // R4: partial write still works after reads
    write_txn(1, 64'h99);
    chk("R4 single byte write", 64'(cfg), 64'h0000_C5C4_C303_5B99);

    chk("R10 no enable change with SCL high", 64'(oe_bad), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule